// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs complete read transactions against a 12-bit serial analog-to-digital converter that uses four wires: an active-low select, a serial clock, a command line into the converter and a result line back from it. A single request takes one control byte. The block keeps the channel, gain and polarity field of that byte and forces the start and clock-mode bits. It sends this command, clocks an acquisition gap and then shifts in the 12-bit result. The result appears as a high byte and a low byte, together with a one-cycle done pulse.

A list mode walks a small table. Entry 0 of the table holds a channel count and entries 1 onward hold one control code per channel. The block converts each channel in turn and sends the results out on a byte stream with valid/ready handshaking, low byte first and then high byte. Back-pressure is handled by holding the current byte and waiting. No new conversion starts until the high byte of the current channel has been taken, so no result is ever dropped or buffered.

Top module: `sadc_seq`

## Requirements
- R1: The command sent is `(code & 8'h7C) | 8'h81`: bits 6..2 of the code pass through, and bit 7 and bit 0 are forced to 1. It is shifted out MSB first on `adc_din`, one bit per serial-clock pulse, and is stable while `adc_sclk` is high.
- R2: `adc_cs_n` falls before the first serial-clock rise and rises only after the last result bit. Every transaction has exactly 25 serial-clock pulses.
- R3: During pulses 9 to 13 (the acquisition gap), `adc_din` is held low.
- R4: Pulses 14 to 25 read the result MSB first. Each bit is sampled at the end of the low phase that follows its pulse. The first 4 bits form `res_hi[3:0]` and the last 8 bits form `res_lo[7:0]`. `res_hi[7:4]` is always zero.
- R5: Every high phase and every low phase of `adc_sclk` inside a transaction lasts `HALF_DIV` system clocks. `adc_sclk` is low whenever `adc_cs_n` is high.
- R6: `busy` is high from the cycle after an accepted request until `done` pulses for one cycle. `busy` falls in the same cycle that `done` is high.
- R7: `start` and `list_start` are ignored while `busy` is high: no extra transaction runs and no stream byte appears.
- R8: If `start` and `list_start` are both high while idle, the single conversion of `ctrl_in` runs and the list is not run.
- R9: A write with `tbl_we` stores `tbl_wdata` at `tbl_addr`. Entry 0 is the count, read from bits 3..0. Entries 1..8 are the channel codes, used in order.
- R10: In list mode each channel yields two stream bytes, the low byte and then the high byte. `st_last` is high only on the final high byte. `done` pulses after that byte is accepted.
- R11: While `st_valid` is high and `st_ready` is low, `st_data` and `st_last` hold steady. No transaction starts while a byte is waiting.
- R12: A count of 0 gives a `done` pulse with no transaction and no stream byte. A count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion of `ctrl_in` |
| ctrl_in | input | 8 | Control byte for a single conversion |
| list_start | input | 1 | Request a pass over the table |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index ($clog2(MAX_CH+1)) |
| tbl_wdata | input | 8 | Table write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 8 | Result bits 7..0 of the latest conversion |
| res_hi | output | 8 | Result bits 11..8 in [3:0], zero above |
| st_valid | output | 1 | Stream byte available |
| st_ready | input | 1 | Stream byte accepted |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a list pass |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_din | output | 1 | Command line to the converter |
| adc_dout | input | 1 | Result line from the converter |

## Verification
The in-RTL assertions check on every cycle that the serial clock only toggles while the converter is selected, and that a transaction never exceeds 25 pulses and releases select only after exactly 25. They also check that `done` accompanies every fall of `busy`, that a waiting stream byte stays stable, and that no transaction overlaps a waiting byte. Other properties only show up in the bench's scenarios against a converter model: the exact command bits after masking, the quiet acquisition line, the phase widths, the bit order of the assembled result, the ignoring of requests while busy, request priority, list ordering, and count clamping.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CMD_BITS     = 8;
  localparam int ACQ_CLKS     = 5;
  localparam int RES_W        = 12;
  localparam int FRAME_PULSES = CMD_BITS + ACQ_CLKS + RES_W;
  localparam int RD_FIRST     = CMD_BITS + ACQ_CLKS + 1;
  localparam int PW           = $clog2(FRAME_PULSES + 1);
  localparam int CSW          = $clog2(CMD_BITS);
  localparam logic [CMD_BITS-1:0] CMD_KEEP  = 8'h7C;
  localparam logic [CMD_BITS-1:0] CMD_FORCE = 8'h81;

  typedef enum logic [1:0] {F_IDLE, F_SETUP, F_HI, F_LO} frame_st_t;
  typedef enum logic [2:0] {T_IDLE, T_SGL, T_LCONV, T_LLO, T_LHI} seq_st_t;
endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [CMD_BITS-1:0] cmd_raw,
  input  logic                adc_dout,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_din,
  output logic                fin,
  output logic [RES_W-1:0]    res
);
  frame_st_t           st;
  logic [PW-1:0]       p;      // completed pulses
  logic [CMD_BITS-1:0] cmd;
  logic [CSW-1:0]      bsel;
  logic                tick;

  sadc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(st != F_IDLE), .tick(tick)
  );

  assign adc_cs_n = (st == F_IDLE);
  assign adc_sclk = (st == F_HI);
  assign bsel     = CSW'(CMD_BITS - 1) - p[CSW-1:0];
  assign adc_din  = (p < PW'(CMD_BITS)) ? cmd[bsel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= F_IDLE;
      p   <= '0;
      cmd <= '0;
      res <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          cmd <= (cmd_raw & CMD_KEEP) | CMD_FORCE;
          p   <= '0;
          st  <= F_SETUP;
        end
        F_SETUP: if (tick) st <= F_HI;
        F_HI: if (tick) begin
          p  <= p + 1'b1;
          st <= F_LO;
        end
        F_LO: if (tick) begin
          if (p >= PW'(RD_FIRST)) res <= {res[RES_W-2:0], adc_dout};
          if (p == PW'(FRAME_PULSES)) begin
            st  <= F_IDLE;
            fin <= 1'b1;
          end else begin
            st <= F_HI;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // checker state: serial-clock rises seen in the current select window
  logic          sclk_d;
  logic [PW-1:0] rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_cs_n)                 rises <= '0;
      else if (adc_sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  a_r5_sclk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);
  a_r2_pulse_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= PW'(FRAME_PULSES));
  a_r2_release_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (rises == PW'(FRAME_PULSES)));
  a_r7_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> adc_cs_n);
endmodule

// File: rtl/sadc_table.sv
module sadc_table #(
  parameter int MAX_CH = 8,
  parameter int DW     = 8,
  localparam int N     = MAX_CH + 1,
  localparam int AW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] count_byte
);
  logic [DW-1:0] ent [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ent[g] <= '0;
      else if (we && waddr == AW'(g))    ent[g] <= wdata;
    end
  end

  assign rdata      = (int'(raddr) < N) ? ent[raddr] : '0;
  assign count_byte = ent[0];
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MAX_CH   = 8,
  localparam int AW      = $clog2(MAX_CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    ctrl_in,
  input  logic          list_start,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [7:0]    tbl_wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    res_lo,
  output logic [7:0]    res_hi,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [7:0]    st_data,
  output logic          st_last,
  output logic          adc_cs_n,
  output logic          adc_sclk,
  output logic          adc_din,
  input  logic          adc_dout
);
  seq_st_t          state;
  logic             go_q;
  logic [7:0]       cmd_q;
  logic [AW-1:0]    ch, cnt, cnt_fld, cnt_clamp;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_code, cnt_byte;
  logic             fin;
  logic [RES_W-1:0] res;

  sadc_table #(.MAX_CH(MAX_CH), .DW(8)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(rd_addr), .rdata(rd_code), .count_byte(cnt_byte)
  );

  sadc_frame #(.HALF_DIV(HALF_DIV)) u_frame (
    .clk(clk), .rst_n(rst_n), .go(go_q), .cmd_raw(cmd_q), .adc_dout(adc_dout),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .fin(fin), .res(res)
  );

  assign cnt_fld   = cnt_byte[AW-1:0];
  assign cnt_clamp = (cnt_fld > AW'(MAX_CH)) ? AW'(MAX_CH) : cnt_fld;
  assign rd_addr   = (state == T_IDLE) ? AW'(1) : ch + AW'(2);

  assign res_lo   = res[7:0];
  assign res_hi   = {{(16 - RES_W){1'b0}}, res[RES_W-1:8]};
  assign busy     = (state != T_IDLE);
  assign st_valid = (state == T_LLO) || (state == T_LHI);
  assign st_data  = (state == T_LHI) ? res_hi : res_lo;
  assign st_last  = (state == T_LHI) && (ch == cnt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= T_IDLE;
      go_q  <= 1'b0;
      cmd_q <= '0;
      done  <= 1'b0;
      ch    <= '0;
      cnt   <= '0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      case (state)
        T_IDLE: begin
          if (start) begin
            cmd_q <= ctrl_in;
            go_q  <= 1'b1;
            state <= T_SGL;
          end else if (list_start) begin
            if (cnt_clamp == '0) begin
              done <= 1'b1;
            end else begin
              cnt   <= cnt_clamp;
              ch    <= '0;
              cmd_q <= rd_code;
              go_q  <= 1'b1;
              state <= T_LCONV;
            end
          end
        end
        T_SGL: if (fin) begin
          done  <= 1'b1;
          state <= T_IDLE;
        end
        T_LCONV: if (fin) state <= T_LLO;
        T_LLO: if (st_ready) state <= T_LHI;
        T_LHI: if (st_ready) begin
          if (st_last) begin
            done  <= 1'b1;
            state <= T_IDLE;
          end else begin
            ch    <= ch + 1'b1;
            cmd_q <= rd_code;
            go_q  <= 1'b1;
            state <= T_LCONV;
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  a_r6_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));
  a_r11_no_frame_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> adc_cs_n);
  a_r10_last_only_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_last |-> st_valid);
endmodule

// File: tb/sadc_seq_tb.sv
module sadc_seq_tb;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, list_start = 1'b0, tbl_we = 1'b0, st_ready = 1'b0;
  logic [7:0] ctrl_in = '0, tbl_wdata = '0;
  logic [3:0] tbl_addr = '0;
  logic busy, done, st_valid, st_last, adc_cs_n, adc_sclk, adc_din;
  logic adc_dout = 1'b0;
  logic [7:0] res_lo, res_hi, st_data;

  always #2.5 clk = ~clk;

  sadc_seq #(.HALF_DIV(HALF), .MAX_CH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_in(ctrl_in),
    .list_start(list_start), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .busy(busy), .done(done), .res_lo(res_lo),
    .res_hi(res_hi), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_last(st_last), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_of(input logic [7:0] c);
    return (c & 8'h7C) | 8'h81;
  endfunction

  // ---------------- converter model ----------------
  logic [11:0] adc_vals [64];
  logic [7:0]  cmd_log  [64];
  int          rise_log [64];
  bit          acq_log  [64];
  int cs_falls = 0, cur = 0, rise_cnt = 0, fall_cnt = 0;
  logic [7:0] cmd_cap;
  bit acq_bad;
  int hi_run = 0, lo_run = 0, width_bad = 0;
  bit seen_valid = 0;

  always @(negedge adc_cs_n) begin
    cur = cs_falls; cs_falls++;
    rise_cnt = 0; fall_cnt = 0; acq_bad = 0; cmd_cap = '0;
  end
  always @(posedge adc_cs_n) begin
    if (cs_falls > 0) begin
      cmd_log[cur] = cmd_cap; rise_log[cur] = rise_cnt; acq_log[cur] = acq_bad;
    end
  end
  always @(posedge adc_sclk) begin
    if (!adc_cs_n) begin
      rise_cnt++;
      if (rise_cnt <= 8) cmd_cap = {cmd_cap[6:0], adc_din};
      else if (rise_cnt <= 13 && adc_din) acq_bad = 1;
    end
  end
  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      fall_cnt++;
      if (fall_cnt >= 14 && fall_cnt <= 25) adc_dout = adc_vals[cur][11 - (fall_cnt - 14)];
    end
  end
  always @(posedge clk) begin
    if (adc_sclk) hi_run++;
    else if (hi_run != 0) begin
      if (hi_run != HALF) width_bad++;
      hi_run = 0;
    end
    if (!adc_sclk && !adc_cs_n) lo_run++;
    else if (adc_sclk && lo_run != 0) begin
      if (lo_run != HALF) width_bad++;
      lo_run = 0;
    end else if (adc_cs_n) lo_run = 0;
  end
  always @(negedge clk) if (st_valid) seen_valid = 1;

  // ---------------- helpers ----------------
  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic tbl_write(input int a, input logic [7:0] d);
    @(negedge clk); tbl_we = 1; tbl_addr = 4'(a); tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(adc_cs_n == 1, "R2 reset select", adc_cs_n, 1);
    chk(adc_sclk == 0, "R5 reset sclk", adc_sclk, 0);
    chk(busy == 0 && done == 0, "R6 reset busy/done", {busy, done}, 0);
    chk(st_valid == 0, "R10 reset valid", st_valid, 0);
  endtask

  task automatic t_single(input logic [7:0] c, input logic [11:0] v);
    int base = cs_falls; bit ok;
    adc_vals[base] = v;
    @(negedge clk); start = 1; ctrl_in = c;
    @(negedge clk); start = 0;
    chk(busy == 1, "R6 busy after start", busy, 1);
    wait_done(ok);
    chk(ok, "R6 done arrives", ok, 1);
    chk(busy == 0, "R6 busy falls with done", busy, 0);
    chk(res_lo == v[7:0], "R4 low byte", res_lo, v[7:0]);
    chk(res_hi == {4'h0, v[11:8]}, "R4 high byte", res_hi, {4'h0, v[11:8]});
    @(negedge clk);
    chk(done == 0, "R6 done one cycle", done, 0);
    chk(cs_falls == base + 1, "R2 one transaction", cs_falls - base, 1);
    chk(cmd_log[base] == cmd_of(c), "R1 command bits", cmd_log[base], cmd_of(c));
    chk(rise_log[base] == 25, "R2 pulse count", rise_log[base], 25);
    chk(acq_log[base] == 0, "R3 acquisition quiet", acq_log[base], 0);
  endtask

  task automatic t_busy_ignore();
    int base = cs_falls; bit ok;
    adc_vals[base] = 12'h001; seen_valid = 0;
    tbl_write(0, 8'd2);
    @(negedge clk); start = 1; ctrl_in = 8'h24;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; list_start = 1; ctrl_in = 8'h7C;
    @(negedge clk); start = 0; list_start = 0;
    wait_done(ok);
    repeat (60) @(negedge clk);
    chk(cs_falls == base + 1, "R7 request while busy ignored", cs_falls - base, 1);
    chk(cmd_log[base] == cmd_of(8'h24), "R7 first command kept", cmd_log[base], cmd_of(8'h24));
    chk(seen_valid == 0 && busy == 0, "R7 no list started", {seen_valid, busy}, 0);
  endtask

  task automatic t_priority();
    int base = cs_falls; bit ok;
    adc_vals[base] = 12'h7A5; seen_valid = 0;
    tbl_write(0, 8'd2);
    @(negedge clk); start = 1; list_start = 1; ctrl_in = 8'h48;
    @(negedge clk); start = 0; list_start = 0;
    wait_done(ok);
    repeat (10) @(negedge clk);
    chk(cs_falls == base + 1, "R8 single wins", cs_falls - base, 1);
    chk(cmd_log[base] == cmd_of(8'h48), "R8 single command", cmd_log[base], cmd_of(8'h48));
    chk(seen_valid == 0, "R8 no stream", seen_valid, 0);
  endtask

  task automatic t_list(input logic [7:0] cnt_entry, input int nch, input bit stall);
    int base = cs_falls, nb = 0, stall_bad = 0, hold_bad = 0;
    logic [7:0] rx [16]; bit rxl [16];
    bit pv = 0, pr = 0; logic [7:0] pd = '0; bit ok = 0;
    tbl_write(0, cnt_entry);
    for (int i = 1; i <= 8; i++) begin
      tbl_write(i, 8'(8'h13 * i + 8'h40));
      adc_vals[base + i - 1] = 12'(12'h123 * i + 12'h05A);
    end
    @(negedge clk); list_start = 1;
    @(negedge clk); list_start = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (done) begin ok = 1; break; end
      st_ready = stall ? (cyc % 4 == 3) : 1'b1;
      if (pv && !pr && st_data != pd) hold_bad++;
      if (st_valid && !adc_cs_n) stall_bad++;
      if (st_valid && st_ready && nb < 16) begin rx[nb] = st_data; rxl[nb] = st_last; nb++; end
      pv = st_valid; pr = st_ready; pd = st_data;
      @(negedge clk);
    end
    st_ready = 0;
    chk(ok, "R10 list done", ok, 1);
    chk(nb == 2 * nch, "R12 byte count", nb, 2 * nch);
    chk(cs_falls - base == nch, "R9 transactions", cs_falls - base, nch);
    for (int i = 0; i < nch && 2 * i + 1 < nb; i++) begin
      logic [11:0] v = adc_vals[base + i];
      logic [7:0] c = cmd_of(8'(8'h13 * (i + 1) + 8'h40));
      chk(rx[2*i] == v[7:0], "R10 low byte first", rx[2*i], v[7:0]);
      chk(rx[2*i+1] == {4'h0, v[11:8]}, "R10 high byte second", rx[2*i+1], {4'h0, v[11:8]});
      chk(rxl[2*i] == 0 && rxl[2*i+1] == (i == nch - 1), "R10 last marker",
          {rxl[2*i], rxl[2*i+1]}, (i == nch - 1) ? 1 : 0);
      chk(cmd_log[base + i] == c, "R9 table code order", cmd_log[base + i], c);
    end
    chk(stall_bad == 0, "R11 no transaction while waiting", stall_bad, 0);
    chk(hold_bad == 0, "R11 data held under stall", hold_bad, 0);
  endtask

  task automatic t_empty();
    int base = cs_falls; bit ok;
    seen_valid = 0;
    tbl_write(0, 8'h50);  // bits 3..0 are zero
    @(negedge clk); list_start = 1;
    @(negedge clk); list_start = 0;
    chk(done == 1, "R12 empty list done", done, 1);
    repeat (40) @(negedge clk);
    chk(cs_falls == base && seen_valid == 0, "R12 empty list silent", cs_falls - base, 0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single(8'h00, 12'hA5C);
    t_single(8'hFF, 12'h3F0);
    t_single(8'h5A, 12'hFFF);
    t_busy_ignore();
    t_priority();
    t_list(8'd3, 3, 1'b1);
    t_list(8'd12, 8, 1'b0);
    t_empty();
    chk(width_bad == 0, "R5 phase widths", width_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule